// File: doc/BRIEF.md
# Programmable Clock Rate Divider

This block holds two 32-bit configuration words. The first describes the multiplier of a PLL: an integer part and a 10-bit fraction. The second packs three 5-bit divisors, each with an enable bit, for three derived domains: display, CPU and memory. From these two words the block continuously reports the PLL rate and each derived rate in kHz.

From a fast reference clock it also produces one enable pulse stream per domain. A fourth stream, the core timer tick, runs at half the CPU domain rate. Logic downstream uses these strobes as clock enables rather than as real clocks.

Software updates the configuration through a simple write port. Either word can be read back at any time. A divisor change never cuts a period short: the new value applies only once the running period has finished.

Top module: `clk_rate_gen`

## Requirements
- R1: Byte address 0x0 holds the PLL word and 0x4 holds the divider word. A write with `wr_en` high lands on the next clock edge. `rdata` shows the word selected by `addr` in the same cycle, or zero for any other address. Writes to any other address change neither word.
- R2: `khz_pll` equals `(12 + W[5:0]) * 33000 / 2 + W[17:8] * 33000 / 2048`, where W is the PLL word and the fractional term is truncated.
- R3: The divider word holds three fields. Display uses divisor [30:26] with enable bit 31, CPU uses divisor [24:20] with enable bit 25, and memory uses divisor [18:14] with enable bit 19. When a domain is enabled with a nonzero divisor, its rate output equals `khz_pll / divisor`, truncated.
- R4: A domain whose enable bit is 0, or whose divisor is 0, reports a rate of 0.
- R5: An active domain with divisor N raises its tick output for one reference cycle in every N, so consecutive ticks are exactly N cycles apart. With N = 1 the tick stays high.
- R6: Once its running period has ended, a domain that is disabled or has a zero divisor produces no ticks.
- R7: A new divisor takes effect at the terminal count of the running period. After a change, the first tick arrives at the old spacing and the ticks after it follow the new spacing.
- R8: `tick_timer` is asserted only together with `tick_cpu`, on every second CPU tick. Its ticks are therefore 2N cycles apart.
- R9: After reset both words are zero. The rates then read 198000 kHz for the PLL and 0 for every domain, and no tick output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| addr | input | ADDR_W | Byte address of the word |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` |
| tick_disp | output | 1 | Display domain enable pulse |
| tick_cpu | output | 1 | CPU domain enable pulse |
| tick_mem | output | 1 | Memory domain enable pulse |
| tick_timer | output | 1 | Core timer tick at half the CPU rate |
| khz_pll | output | KHZ_W | PLL rate in kHz |
| khz_disp | output | KHZ_W | Display rate in kHz |
| khz_cpu | output | KHZ_W | CPU rate in kHz |
| khz_mem | output | KHZ_W | Memory rate in kHz |

## Verification
A wrong field decode or a wrong rate formula shows on the kHz outputs in the same cycle as the write that caused it. The bench therefore sweeps every divisor of every domain, and every integer multiplier combined with fractional boundary values.

A corrupted period counter or a corrupted latched divisor shows within one period, at most 31 reference cycles, as a wrong spacing between ticks. The bench measures that spacing directly.

A divisor that is applied too early shows in the first interval after a mid-period write. A slipped timer phase shows within two CPU periods.

// File: rtl/clk_rate_gen.sv
module clk_rate_gen #(
  parameter int DIV_W  = 5,
  parameter int INT_W  = 6,
  parameter int FRAC_W = 10,
  parameter int ADDR_W = 3,
  parameter int KHZ_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  output logic              tick_disp,
  output logic              tick_cpu,
  output logic              tick_mem,
  output logic              tick_timer,
  output logic [KHZ_W-1:0]  khz_pll,
  output logic [KHZ_W-1:0]  khz_disp,
  output logic [KHZ_W-1:0]  khz_cpu,
  output logic [KHZ_W-1:0]  khz_mem
);
  localparam int NDOM     = 3;
  localparam int FRAC_LSB = 8;
  localparam int BASE_MUL = 12;
  localparam int STEP_KHZ = 33000;
  localparam logic [ADDR_W-1:0] A_PLL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_DIV = ADDR_W'(4);

  logic [31:0] pll_q, div_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pll_q <= '0;
      div_q <= '0;
    end else if (wr_en) begin
      if (addr == A_PLL) pll_q <= wdata;
      if (addr == A_DIV) div_q <= wdata;
    end
  end

  assign rdata = (addr == A_PLL) ? pll_q : (addr == A_DIV) ? div_q : '0;

  logic [31:0] int_part, frac_part;
  assign int_part  = ((BASE_MUL + 32'(pll_q[INT_W-1:0])) * STEP_KHZ) >> 1;
  assign frac_part = (32'(pll_q[FRAC_LSB +: FRAC_W]) * STEP_KHZ) >> (FRAC_W + 1);
  assign khz_pll   = KHZ_W'(int_part + frac_part);

  logic [NDOM-1:0] tick, live;
  logic [KHZ_W-1:0] khz [NDOM];

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    localparam int LSB = (g == 0) ? 26 : (g == 1) ? 20 : 14;
    logic [DIV_W-1:0] cfg, act, cnt;
    logic on;

    assign on  = div_q[LSB+DIV_W] && (div_q[LSB +: DIV_W] != '0);
    assign cfg = on ? div_q[LSB +: DIV_W] : '0;
    assign live[g] = (act != '0);
    assign tick[g] = live[g] && (cnt == act - 1'b1);
    assign khz[g]  = on ? khz_pll / KHZ_W'(cfg) : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        act <= '0;
        cnt <= '0;
      end else if (!live[g] || tick[g]) begin
        act <= cfg;
        cnt <= '0;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

  logic half;
  always_ff @(posedge clk) begin
    if (!rst_n || !live[1]) half <= 1'b0;
    else if (tick[1])       half <= ~half;
  end

  assign tick_disp  = tick[0];
  assign tick_cpu   = tick[1];
  assign tick_mem   = tick[2];
  assign tick_timer = tick[1] & half;
  assign khz_disp   = khz[0];
  assign khz_cpu    = khz[1];
  assign khz_mem    = khz[2];
endmodule

// File: rtl/clk_rate_gen_chk.sv
module clk_rate_gen_chk #(
  parameter int ADDR_W = 3,
  parameter int KHZ_W  = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic [31:0]       wdata,
  input logic [31:0]       div_q,
  input logic [KHZ_W-1:0]  khz_pll,
  input logic [KHZ_W-1:0]  khz_cpu,
  input logic              tick_cpu,
  input logic              tick_timer
);
  p_div_write_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(4)) |=> div_q == $past(wdata));

  p_pll_floor_r2: assert property (@(posedge clk) disable iff (!rst_n)
    khz_pll >= KHZ_W'(198000));

  p_rate_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    khz_cpu <= khz_pll);

  p_rate_off_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!div_q[25] || div_q[24:20] == 5'd0) |-> khz_cpu == '0);

  p_timer_on_cpu_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_timer |-> tick_cpu);

  p_timer_alt_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tick_timer |=> !tick_timer);
endmodule

bind clk_rate_gen clk_rate_gen_chk #(.ADDR_W(ADDR_W), .KHZ_W(KHZ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
  .div_q(div_q), .khz_pll(khz_pll), .khz_cpu(khz_cpu),
  .tick_cpu(tick_cpu), .tick_timer(tick_timer)
);

// File: tb/test_clk_rate_gen.sv
module test_clk_rate_gen;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic tick_disp, tick_cpu, tick_mem, tick_timer;
  logic [31:0] khz_pll, khz_disp, khz_cpu, khz_mem;
  int checks = 0, failures = 0;

  always #2 clk = ~clk;

  clk_rate_gen i_clk_rate_gen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .tick_disp(tick_disp), .tick_cpu(tick_cpu),
    .tick_mem(tick_mem), .tick_timer(tick_timer), .khz_pll(khz_pll),
    .khz_disp(khz_disp), .khz_cpu(khz_cpu), .khz_mem(khz_mem));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic tk(int d);
    case (d)
      0: return tick_disp;
      1: return tick_cpu;
      3: return tick_timer;
      default: return tick_mem;
    endcase
  endfunction

  function automatic logic [31:0] kz(int d);
    case (d)
      0: return khz_disp;
      1: return khz_cpu;
      default: return khz_mem;
    endcase
  endfunction

  function automatic logic [31:0] dword(int d, bit en, int dv);
    int lsb = (d == 0) ? 26 : (d == 1) ? 20 : 14;
    return (32'(en) << (lsb + 5)) | (32'(dv) << lsb);
  endfunction

  function automatic longint epll(logic [31:0] w);
    return ((12 + longint'(w[5:0])) * 33000) / 2 + (longint'(w[17:8]) * 33000) / 2048;
  endfunction

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0; addr = 3'd0;
  endtask

  task automatic meas(input int d, output int iv);
    int k = 0;
    while (!tk(d) && k < 200) begin @(negedge clk); k++; end
    k = 0;
    do begin @(negedge clk); k++; end while (!tk(d) && k < 200);
    iv = k;
  endtask

  task automatic count_ticks(input int d, input int n, output int c);
    c = 0;
    for (int i = 0; i < n; i++) begin @(negedge clk); if (tk(d)) c++; end
  endtask

  initial begin
    #(4 * 150000);
    failures++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int iv, c;
    logic [31:0] pw;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9 reset state
    chk(khz_pll == 198000, "R9 pll", khz_pll, 198000);
    chk(khz_disp == 0 && khz_cpu == 0 && khz_mem == 0, "R9 rates", khz_cpu, 0);
    chk(rdata == 0, "R9 rdata", rdata, 0);
    count_ticks(0, 10, c); chk(c == 0, "R9 no disp ticks", c, 0);
    count_ticks(1, 10, c); chk(c == 0, "R9 no cpu ticks", c, 0);
    count_ticks(3, 10, c); chk(c == 0, "R9 no timer ticks", c, 0);

    // R1 register access
    wr(3'd0, 32'h0003_0a15);
    wr(3'd4, 32'hA5A5_5A5A);
    addr = 3'd0; #1; chk(rdata == 32'h0003_0a15, "R1 pll readback", rdata, 32'h0003_0a15);
    addr = 3'd4; #1; chk(rdata == 32'hA5A5_5A5A, "R1 div readback", rdata, 32'hA5A5_5A5A);
    addr = 3'd2; #1; chk(rdata == 0, "R1 other addr reads 0", rdata, 0);
    wr(3'd1, 32'hFFFF_FFFF);
    wr(3'd5, 32'h1234_5678);
    addr = 3'd0; #1; chk(rdata == 32'h0003_0a15, "R1 stray write pll", rdata, 32'h0003_0a15);
    addr = 3'd4; #1; chk(rdata == 32'hA5A5_5A5A, "R1 stray write div", rdata, 32'hA5A5_5A5A);
    addr = 3'd0;

    // R2 PLL rate sweep, R3 cpu rate tracks it
    wr(3'd4, dword(1, 1'b1, 3));
    for (int m = 0; m < 64; m++) begin
      for (int fi = 0; fi < 4; fi++) begin
        int f = (fi == 0) ? 0 : (fi == 1) ? 1 : (fi == 2) ? 512 : 1023;
        pw = 32'(m) | (32'(f) << 8) | 32'hFFFC_00C0;
        wr(3'd0, pw);
        chk(khz_pll == 32'(epll(pw)), "R2 pll khz", khz_pll, epll(pw));
        chk(khz_cpu == 32'(epll(pw) / 3), "R3 cpu khz", khz_cpu, epll(pw) / 3);
      end
    end

    // R3 R5 every divisor of every domain
    pw = 32'h0002_8017;
    wr(3'd0, pw);
    for (int d = 0; d < 3; d++) begin
      for (int dv = 1; dv < 32; dv++) begin
        wr(3'd4, dword(d, 1'b1, dv));
        chk(kz(d) == 32'(epll(pw) / dv), "R3 domain khz", kz(d), epll(pw) / dv);
        chk(kz((d + 1) % 3) == 0, "R4 other domain zero", kz((d + 1) % 3), 0);
        meas(d, iv); chk(iv == dv, "R5 tick spacing", iv, dv);
        meas(d, iv); chk(iv == dv, "R5 tick spacing repeat", iv, dv);
        if (d == 1) begin
          meas(3, iv); chk(iv == 2 * dv, "R8 timer spacing", iv, 2 * dv);
          chk(tick_cpu == 1'b1, "R8 timer with cpu", tick_cpu, 1);
        end
      end
    end

    // R4 R6 disabled and zero divisor
    wr(3'd4, dword(1, 1'b0, 7));
    chk(khz_cpu == 0, "R4 enable off", khz_cpu, 0);
    repeat (40) @(negedge clk);
    count_ticks(1, 100, c); chk(c == 0, "R6 enable off no ticks", c, 0);
    count_ticks(3, 20, c); chk(c == 0, "R6 timer off", c, 0);
    wr(3'd4, dword(1, 1'b1, 5));
    meas(1, iv);
    wr(3'd4, dword(1, 1'b1, 0));
    chk(khz_cpu == 0, "R4 zero divisor", khz_cpu, 0);
    repeat (40) @(negedge clk);
    count_ticks(1, 100, c); chk(c == 0, "R6 zero divisor no ticks", c, 0);

    // R7 change at terminal count
    wr(3'd4, dword(1, 1'b1, 8));
    meas(1, iv); chk(iv == 8, "R7 setup spacing", iv, 8);
    begin
      int k = 0;
      @(negedge clk); k++;
      wr_en = 1'b1; addr = 3'd4; wdata = dword(1, 1'b1, 3);
      @(negedge clk); k++;
      wr_en = 1'b0; addr = 3'd0;
      while (!tick_cpu && k < 100) begin @(negedge clk); k++; end
      chk(k == 8, "R7 old period completes", k, 8);
    end
    meas(1, iv); chk(iv == 3, "R7 new spacing", iv, 3);

    // R5 divisor one holds tick high
    wr(3'd4, dword(2, 1'b1, 1));
    repeat (40) @(negedge clk);
    count_ticks(2, 20, c); chk(c == 20, "R5 divisor one", c, 20);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule